// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is a single-cycle 8-bit arithmetic unit that owns an accumulator and a six-bit status register (negative, overflow, zero, carry, interrupt-disable, decimal). Each cycle in which `op_valid` is high it takes an opcode byte and an operand byte and executes one instruction. The instruction set is a subset of a classic 8-bit microprocessor: add with carry, subtract with carry, memory increment and decrement, a load of the accumulator, and the seven instructions that set or clear single flags. Address modes and memory access are not handled here. The operand is always presented on `op_data`, whether it is an immediate byte or a byte that was already fetched.

Subtraction uses the same adder as addition, with the operand bitwise inverted, so carry works as an inverted borrow. Increment and decrement do not touch the accumulator. Their result leaves on `wb_data`, together with a one-cycle `wb_en` pulse that a memory stage can use to write the byte back. The decimal flag can be set and cleared but is only stored, and arithmetic is always binary.

Top module: `acc_flag_alu`

## Requirements
- R1: Add with carry (opcodes 0x69, 0x65, 0x75, 0x6D, 0x7D, 0x79, 0x61, 0x71) forms the 9-bit sum A + operand + C. The accumulator takes its low 8 bits and C takes bit 8.
- R2: After add or subtract, V is bit 7 of ((A xor result) and (B xor result)), where B is the adder's second input (the operand, or the inverted operand for subtract). No flag opcode can set V.
- R3: Subtract with carry (opcodes 0xE9, 0xE5, 0xF5, 0xED, 0xFD, 0xF9, 0xE1, 0xF1) computes A + (operand xor 0xFF) + C. C set after the operation means no borrow, and C clear means a borrow occurred.
- R4: After add, subtract, increment, decrement and load, N equals bit 7 of the 8-bit result and Z is 1 exactly when that result is 0x00.
- R5: Increment (0xE6, 0xF6, 0xEE, 0xFE) and decrement (0xC6, 0xD6, 0xCE, 0xDE) put operand plus or minus one, modulo 256, on `wb_data` and raise `wb_en` for exactly one cycle. The accumulator, C, V, I and D keep their values.
- R6: Opcode 0x18 clears C, 0x38 sets C, 0x58 clears I, 0x78 sets I, 0xB8 clears V, 0xD8 clears D and 0xF8 sets D. All other state is left unchanged.
- R7: Opcode 0xA9 loads the operand into the accumulator. Only N and Z change.
- R8: An unrecognised opcode, or any cycle with `op_valid` low, leaves the accumulator, all flags and `wb_data` unchanged and keeps `wb_en` low.
- R9: While the synchronous active-high `rst` is high, the accumulator, all flags, `wb_data` and `wb_en` are cleared at each clock edge.
- R10: All outputs are registered. An instruction sampled at a rising edge shows its effect right after that edge, and no output follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction strobe |
| op_code | input | 8 | Opcode byte |
| op_data | input | 8 | Operand byte (immediate or fetched data) |
| acc_out | output | 8 | Accumulator |
| wb_data | output | 8 | Increment/decrement result for write-back |
| wb_en | output | 1 | One-cycle write-back enable |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_i | output | 1 | Interrupt-disable flag |
| flag_d | output | 1 | Decimal flag (stored only) |

## Verification
All state sits directly on the ports, so a wrong accumulator or flag value is visible in the cycle right after the instruction that caused it. It also feeds every later add or subtract through the carry-in. A carry that is corrupted by increment or decrement therefore shows as an off-by-one sum in the next arithmetic instruction. A decoder fault shows either as a state change after an unknown opcode or as a stray `wb_en` pulse. The bench compares every port against its own model after each instruction and after the idle cycle that follows it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int MSB    = DATA_W - 1;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_INC, K_DEC, K_LOAD,
        K_CLC, K_SEC, K_CLI, K_SEI, K_CLV, K_CLD, K_SED
    } op_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
        logic i;
        logic d;
    } flags_t;

    typedef struct packed {
        op_kind_e kind;
        logic     use_adder;
        logic     invert;
        logic     step;
        logic     step_down;
    } ctrl_t;

    function automatic op_kind_e classify(input logic [7:0] code);
        op_kind_e k;
        unique case (code)
            8'h69, 8'h65, 8'h75, 8'h6D, 8'h7D, 8'h79, 8'h61, 8'h71: k = K_ADD;
            8'hE9, 8'hE5, 8'hF5, 8'hED, 8'hFD, 8'hF9, 8'hE1, 8'hF1: k = K_SUB;
            8'hE6, 8'hF6, 8'hEE, 8'hFE: k = K_INC;
            8'hC6, 8'hD6, 8'hCE, 8'hDE: k = K_DEC;
            8'hA9: k = K_LOAD;
            8'h18: k = K_CLC;
            8'h38: k = K_SEC;
            8'h58: k = K_CLI;
            8'h78: k = K_SEI;
            8'hB8: k = K_CLV;
            8'hD8: k = K_CLD;
            8'hF8: k = K_SED;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic all_zero(input logic [DATA_W-1:0] val);
        return (val == '0);
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic       valid,
    input  logic [7:0] code,
    output ctrl_t      ctrl
);
    op_kind_e kind_raw;

    always_comb begin
        kind_raw       = valid ? classify(code) : K_NONE;
        ctrl.kind      = kind_raw;
        ctrl.use_adder = (kind_raw == K_ADD) || (kind_raw == K_SUB);
        ctrl.invert    = (kind_raw == K_SUB);
        ctrl.step      = (kind_raw == K_INC) || (kind_raw == K_DEC);
        ctrl.step_down = (kind_raw == K_DEC);
    end
endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         invert,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    assign b_eff    = invert ? ~b : b;
    assign chain[0] = cin;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign sum[g]     = a[g] ^ b_eff[g] ^ chain[g];
        assign chain[g+1] = (a[g] & b_eff[g]) | (chain[g] & (a[g] ^ b_eff[g]));
    end

    assign cout = chain[W];
    // signed overflow: carry into the sign bit differs from carry out of it
    assign ovf  = chain[W] ^ chain[W-1];
endmodule

// File: rtl/acc_alu_step.sv
module acc_alu_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ONE = W'(1);

    assign res = down ? (val - ONE) : (val + ONE);
endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic [7:0] op_data,
    output logic [7:0] acc_out,
    output logic [7:0] wb_data,
    output logic       wb_en,
    output logic       flag_n,
    output logic       flag_v,
    output logic       flag_z,
    output logic       flag_c,
    output logic       flag_i,
    output logic       flag_d
);
    ctrl_t             ctl;
    logic [DATA_W-1:0] acc_q, acc_d, wb_q, wb_d;
    logic              wb_en_q, wb_en_d;
    flags_t            fl_q, fl_d;
    logic [DATA_W-1:0] add_sum, step_res;
    logic              add_cout, add_ovf;

    acc_alu_decode u_dec (
        .valid (op_valid),
        .code  (op_code),
        .ctrl  (ctl)
    );

    acc_alu_adder #(.W(DATA_W)) u_add (
        .a      (acc_q),
        .b      (op_data),
        .cin    (fl_q.c),
        .invert (ctl.invert),
        .sum    (add_sum),
        .cout   (add_cout),
        .ovf    (add_ovf)
    );

    acc_alu_step #(.W(DATA_W)) u_step (
        .val  (op_data),
        .down (ctl.step_down),
        .res  (step_res)
    );

    always_comb begin
        acc_d   = acc_q;
        fl_d    = fl_q;
        wb_d    = wb_q;
        wb_en_d = 1'b0;
        if (ctl.use_adder) begin
            acc_d  = add_sum;
            fl_d.c = add_cout;
            fl_d.v = add_ovf;
            fl_d.n = add_sum[MSB];
            fl_d.z = all_zero(add_sum);
        end else if (ctl.step) begin
            wb_d    = step_res;
            wb_en_d = 1'b1;
            fl_d.n  = step_res[MSB];
            fl_d.z  = all_zero(step_res);
        end else begin
            unique case (ctl.kind)
                K_LOAD: begin
                    acc_d  = op_data;
                    fl_d.n = op_data[MSB];
                    fl_d.z = all_zero(op_data);
                end
                K_CLC:   fl_d.c = 1'b0;
                K_SEC:   fl_d.c = 1'b1;
                K_CLI:   fl_d.i = 1'b0;
                K_SEI:   fl_d.i = 1'b1;
                K_CLV:   fl_d.v = 1'b0;
                K_CLD:   fl_d.d = 1'b0;
                K_SED:   fl_d.d = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            fl_q    <= '0;
            wb_q    <= '0;
            wb_en_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            fl_q    <= fl_d;
            wb_q    <= wb_d;
            wb_en_q <= wb_en_d;
        end
    end

    assign acc_out = acc_q;
    assign wb_data = wb_q;
    assign wb_en   = wb_en_q;
    assign flag_n  = fl_q.n;
    assign flag_v  = fl_q.v;
    assign flag_z  = fl_q.z;
    assign flag_c  = fl_q.c;
    assign flag_i  = fl_q.i;
    assign flag_d  = fl_q.d;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [7:0] op_code,
    input logic [7:0] op_data,
    input logic [7:0] acc_out,
    input logic [7:0] wb_data,
    input logic       wb_en,
    input logic       flag_n,
    input logic       flag_v,
    input logic       flag_z,
    input logic       flag_c,
    input logic       flag_i,
    input logic       flag_d
);
    logic is_step, is_arith, is_add, is_sec;
    assign is_step  = op_valid && (classify(op_code) == K_INC || classify(op_code) == K_DEC);
    assign is_arith = op_valid && (classify(op_code) == K_ADD || classify(op_code) == K_SUB
                                   || classify(op_code) == K_LOAD);
    assign is_add   = op_valid && (classify(op_code) == K_ADD || classify(op_code) == K_SUB);
    assign is_sec   = op_valid && (op_code == 8'h38);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_out == 8'h00 && !wb_en && !flag_n && !flag_v && !flag_z
                 && !flag_c && !flag_i && !flag_d)); // R9

    AST_WB_ONLY_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> $past(is_step)); // R5

    AST_STEP_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
        is_step |=> ($stable(flag_c) && $stable(flag_v) && $stable(acc_out)
                     && $stable(flag_i) && $stable(flag_d))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_out) && $stable(wb_data) && !wb_en && $stable(flag_n)
                       && $stable(flag_v) && $stable(flag_z) && $stable(flag_c)
                       && $stable(flag_i) && $stable(flag_d))); // R8

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
        is_arith |=> (flag_z == (acc_out == 8'h00) && flag_n == acc_out[7])); // R4

    AST_SET_CARRY: assert property (@(posedge clk) disable iff (rst)
        is_sec |=> flag_c); // R6

    AST_V_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_v) |-> $past(is_add)); // R2
endmodule

bind acc_flag_alu acc_alu_checker u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .acc_out(acc_out), .wb_data(wb_data), .wb_en(wb_en), .flag_n(flag_n),
    .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .flag_i(flag_i), .flag_d(flag_d)
);

// File: tb/acc_flag_alu_bench.sv
`timescale 1ns/1ps
module acc_flag_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic [7:0] op_data = 8'h00;
    logic [7:0] acc_out, wb_data;
    logic       wb_en, flag_n, flag_v, flag_z, flag_c, flag_i, flag_d;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    int m_acc, m_wb, m_n, m_v, m_z, m_c, m_i, m_d, m_wben;

    always #2 clk = ~clk;

    acc_flag_alu u_acc_flag_alu (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .acc_out(acc_out), .wb_data(wb_data), .wb_en(wb_en), .flag_n(flag_n),
        .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c), .flag_i(flag_i), .flag_d(flag_d)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "acc", acc_out, m_acc);
        chk(req, "wb_data", wb_data, m_wb);
        chk(req, "wb_en", wb_en, m_wben);
        chk(req, "N", flag_n, m_n);
        chk(req, "V", flag_v, m_v);
        chk(req, "Z", flag_z, m_z);
        chk(req, "C", flag_c, m_c);
        chk(req, "I", flag_i, m_i);
        chk(req, "D", flag_d, m_d);
    endtask

    function automatic void set_nz(input int r);
        m_n = (r >> 7) & 1;
        m_z = (r == 0) ? 1 : 0;
    endfunction

    function automatic void adder(input int b);
        int s;
        s     = m_acc + b + m_c;
        m_v   = (((m_acc ^ s) & (b ^ s) & 8'h80) != 0) ? 1 : 0;
        m_c   = (s >> 8) & 1;
        m_acc = s & 8'hFF;
        set_nz(m_acc);
    endfunction

    // reference behaviour; returns the requirement tag the opcode belongs to
    function automatic string model(input int code, input int data);
        m_wben = 0;
        case (code)
            8'h69, 8'h65, 8'h75, 8'h6D, 8'h7D, 8'h79, 8'h61, 8'h71: begin
                adder(data); return "R1";
            end
            8'hE9, 8'hE5, 8'hF5, 8'hED, 8'hFD, 8'hF9, 8'hE1, 8'hF1: begin
                adder((~data) & 8'hFF); return "R3";
            end
            8'hE6, 8'hF6, 8'hEE, 8'hFE: begin
                m_wb = (data + 1) & 8'hFF; m_wben = 1; set_nz(m_wb); return "R5";
            end
            8'hC6, 8'hD6, 8'hCE, 8'hDE: begin
                m_wb = (data + 255) & 8'hFF; m_wben = 1; set_nz(m_wb); return "R5";
            end
            8'hA9: begin m_acc = data; set_nz(data); return "R7"; end
            8'h18: begin m_c = 0; return "R6"; end
            8'h38: begin m_c = 1; return "R6"; end
            8'h58: begin m_i = 0; return "R6"; end
            8'h78: begin m_i = 1; return "R6"; end
            8'hB8: begin m_v = 0; return "R6"; end
            8'hD8: begin m_d = 0; return "R6"; end
            8'hF8: begin m_d = 1; return "R6"; end
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input int code, input int data);
        string tag;
        @(negedge clk);
        chk("R5", "wb_en after idle", wb_en, 0);
        op_valid = 1'b1;
        op_code  = code[7:0];
        op_data  = data[7:0];
        @(negedge clk);
        op_valid = 1'b0;
        tag = model(code, data);
        m_wben_hold();
        chk_all(tag);
        m_wben = 0;
    endtask

    function automatic void m_wben_hold();
    endfunction

    task automatic apply_idle(input int code, input int data);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = code[7:0];
        op_data  = data[7:0];
        @(negedge clk);
        chk_all("R8");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        m_acc = 0; m_wb = 0; m_n = 0; m_v = 0; m_z = 0; m_c = 0; m_i = 0; m_d = 0; m_wben = 0;
        // preload outputs with non-zero state before reset to make reset meaningful
        repeat (3) @(negedge clk);
        rst = 1'b0;
        apply(8'hA9, 8'h5A);
        apply(8'h78, 8'h00);
        apply(8'hF8, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_acc = 0; m_wb = 0; m_n = 0; m_v = 0; m_z = 0; m_c = 0; m_i = 0; m_d = 0; m_wben = 0;
        chk_all("R9");

        // directed sequence: borrow chain then signed overflow
        apply(8'h38, 8'h00);
        apply(8'hA9, 8'h09);
        apply(8'hE9, 8'h03);
        chk("R3", "acc 9-3", acc_out, 8'h06);
        chk("R3", "no borrow", flag_c, 1);
        apply(8'hE9, 8'h07);
        chk("R3", "acc 6-7", acc_out, 8'hFF);
        chk("R3", "borrow", flag_c, 0);
        apply(8'h69, 8'h80);
        chk("R2", "V on -1+-128", flag_v, 1);
        chk("R1", "acc", acc_out, 8'h7F);
        chk("R1", "carry out", flag_c, 1);
        // increment/decrement corners, carry and V must survive
        apply(8'hE6, 8'h7F);
        chk("R5", "inc 7F", wb_data, 8'h80);
        chk("R4", "N after inc", flag_n, 1);
        apply(8'hC6, 8'h00);
        chk("R5", "dec 00", wb_data, 8'hFF);
        apply(8'hEE, 8'hFF);
        chk("R4", "Z after inc FF", flag_z, 1);
        chk("R5", "V kept", flag_v, 1);
        chk("R5", "C kept", flag_c, 1);
        apply(8'hB8, 8'h00);
        chk("R6", "V cleared", flag_v, 0);
        apply(8'hA9, 8'h80);
        apply(8'h18, 8'h00);
        apply(8'hE9, 8'h01);  // 0x80 - 1 - 1 = 0x7E, sign flip sets V
        chk("R2", "V on subtract", flag_v, 1);
        // ignored stimulus
        apply_idle(8'h69, 8'h11);
        apply_idle(8'hE6, 8'h22);
        apply(8'h02, 8'h33);
        apply(8'hFF, 8'h44);
        // registered outputs: no combinational path
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'hA9; op_data = 8'h3C;
        #1;
        chk("R10", "acc before edge", acc_out, m_acc);
        @(negedge clk);
        op_valid = 1'b0;
        void'(model(8'hA9, 8'h3C));
        chk("R10", "acc after edge", acc_out, 8'h3C);

        // constrained random mix
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h1234_5678);
        end
        for (int n = 0; n < 400; n++) begin
            int r, code, data;
            int known[30] = '{8'h69, 8'h65, 8'h75, 8'h6D, 8'h7D, 8'h79, 8'h61, 8'h71,
                              8'hE9, 8'hE5, 8'hF5, 8'hED, 8'hFD, 8'hF9, 8'hE1, 8'hF1,
                              8'hE6, 8'hF6, 8'hC6, 8'hDE, 8'hA9, 8'h18, 8'h38, 8'h58,
                              8'h78, 8'hB8, 8'hD8, 8'hF8, 8'hEE, 8'hCE};
            r    = $urandom % 10;
            code = (r == 0) ? ($urandom % 256) : known[$urandom % 30];
            data = $urandom % 256;
            if (r == 1) apply_idle(code, data);
            else apply(code, data);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule